// File: doc/BRIEF.md
# SDRAM Power-Up and Special-Command Sequencer

This block brings an SDRAM out of power-up and then lets system software issue single special commands to it. After reset it waits a programmable number of clock cycles for the supply to settle. It then closes every bank, runs a programmable number of auto-refresh cycles, and loads the device mode register. Each of these init commands is followed by a fixed number of idle cycles. When the mode register write and its idle time are over, it raises a done flag and stays in run state.

In run state a 3-bit operation code selects normal operation or one of seven special commands. Each trigger pulse stands in for the dummy access that would carry the command. A trigger issues the selected command exactly once, on the clock after it is sampled. The mode register word is built from four configuration fields. It is placed on the low address lines and every other address and bank line is held low. A free-running two-stage timer (an 8-bit prescaler times an 8-bit period) raises an auto-refresh request. The request is held until the refresh scheduler acknowledges it.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, the pins show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), cke is high, bank and address are zero, and init_done and rfsh_req are low.
- R2: Counting clock edges from reset release as cycle 1, precharge-all (0,0,1,0 with address bit 10 high) appears in cycle WAIT_CYCLES+1. NUM_REFRESH auto-refresh commands (0,0,0,1) follow at a spacing of CMD_GAP+1 cycles, then the mode register write (0,0,0,0). Every other cycle is NOP.
- R3: The mode register write drives burst length code {0,cfg_bl} on address bits 2:0, cfg_bt on bit 3, CAS latency {0,cfg_cl} on bits 6:4 and cfg_wb_single on bit 9. Bits 8:7, every bit above 9 and the bank lines are zero.
- R4: init_done rises CMD_GAP cycles after the init mode register write and stays high until the next reset.
- R5: Before init_done, triggers and operation codes have no effect on the pins.
- R6: After init_done, a trigger sampled at a clock edge issues exactly one command after that edge. Op 001 gives refresh, op 011 gives the mode register write, op 101 gives precharge with bit 10 high. Without a trigger the pins show NOP.
- R7: A trigger with op 000 (normal operation) issues no command.
- R8: Op 100 gives a precharge (0,0,1,0) to cmd_bank with bit 10 low. Op 110 gives an activate (0,0,1,1) with cmd_bank and cmd_addr. Op 111 gives a write (0,1,0,0) when cmd_write is 1 and a read (0,1,0,1) when it is 0, with cmd_bank and cmd_addr but bit 10 forced low.
- R9: Op 010 issues a refresh with cke low, and cke stays low. The next trigger, whatever its op, raises cke and issues only a NOP.
- R10: rfsh_req rises rfsh_period × rfsh_scale cycles after init_done rises, and the timer expires again at every further multiple of that count.
- R11: rfsh_req stays high until rfsh_ack clears it. If a timer expiry lands on the same edge as the acknowledge, the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Special-command selector |
| cmd_trig | input | 1 | One-cycle trigger for a special command |
| cmd_write | input | 1 | Direction for op 111 (1 = write) |
| cmd_bank | input | BA_W | Bank for single-bank commands |
| cmd_addr | input | ADDR_W | Row or column address for commands |
| cfg_bl | input | 2 | Burst length code (1,2,4,8) |
| cfg_bt | input | 1 | Burst type, 1 = interleaved |
| cfg_cl | input | 2 | CAS latency, 1 to 3 |
| cfg_wb_single | input | 1 | Write bursts single-beat when 1 |
| rfsh_period | input | 8 | Refresh period in prescaler ticks |
| rfsh_scale | input | 8 | Prescaler count in clocks |
| rfsh_ack | input | 1 | Clears the pending refresh request |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Init sequence complete |
| rfsh_req | output | 1 | Pending auto-refresh request |

## Verification
A wrong sequencer count shows up in the init phase. A misplaced or missing command shifts a command off its expected cycle, and the mismatch is seen in that same cycle. A stale self-refresh flag shows up as a wrong cke level or an unexpected command one cycle after the next trigger. A wrong prescaler or period count changes when rfsh_req rises. That error shows up only when the first interval ends, so the interval is measured exactly from the rise of init_done.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int WAIT_CYCLES = 20000,
  parameter int NUM_REFRESH = 8,
  parameter int CMD_GAP     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic              cmd_trig,
  input  logic              cmd_write,
  input  logic [BA_W-1:0]   cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cfg_bl,
  input  logic              cfg_bt,
  input  logic [1:0]        cfg_cl,
  input  logic              cfg_wb_single,
  input  logic [7:0]        rfsh_period,
  input  logic [7:0]        rfsh_scale,
  input  logic              rfsh_ack,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done,
  output logic              rfsh_req
);
  localparam int CNT_W  = $clog2(WAIT_CYCLES + CMD_GAP + 2);
  localparam int RCNT_W = $clog2(NUM_REFRESH + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;

  typedef enum logic [2:0] {ST_WAIT, ST_PALL, ST_REF, ST_MRS, ST_RUN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [RCNT_W-1:0] rcnt;
  logic [3:0]        cmd_q, cmd_d;
  logic              cke_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d, mode_word;
  logic              first, last;
  logic [7:0]        pre_cnt, per_cnt;
  logic              tick, expire;

  assign first     = (cnt == '0);
  assign last      = (cnt == CNT_W'(CMD_GAP));
  assign init_done = (st == ST_RUN);
  assign mode_word = ADDR_W'({cfg_wb_single, 2'b00, 1'b0, cfg_cl, cfg_bt, 1'b0, cfg_bl});
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_WAIT;
      cnt  <= '0;
      rcnt <= '0;
    end else begin
      case (st)
        ST_WAIT:
          if (cnt == CNT_W'(WAIT_CYCLES - 1)) begin
            st  <= ST_PALL;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        ST_PALL, ST_MRS:
          if (last) begin
            cnt <= '0;
            st  <= (st == ST_PALL) ? ST_REF : ST_RUN;
          end else cnt <= cnt + 1'b1;
        ST_REF:
          if (last) begin
            cnt <= '0;
            if (rcnt == RCNT_W'(NUM_REFRESH - 1)) begin
              rcnt <= '0;
              st   <= ST_MRS;
            end else rcnt <= rcnt + 1'b1;
          end else cnt <= cnt + 1'b1;
        default: st <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    cmd_d  = C_NOP;
    cke_d  = sd_cke;
    ba_d   = '0;
    addr_d = '0;
    case (st)
      ST_PALL: if (first) begin cmd_d = C_PRE; addr_d[10] = 1'b1; end
      ST_REF:  if (first) cmd_d = C_REF;
      ST_MRS:  if (first) begin cmd_d = C_MRS; addr_d = mode_word; end
      ST_RUN:
        if (cmd_trig) begin
          if (!sd_cke) cke_d = 1'b1;
          else begin
            case (op_code)
              3'b001: cmd_d = C_REF;
              3'b010: begin cmd_d = C_REF; cke_d = 1'b0; end
              3'b011: begin cmd_d = C_MRS; addr_d = mode_word; end
              3'b100: begin cmd_d = C_PRE; ba_d = cmd_bank; end
              3'b101: begin cmd_d = C_PRE; addr_d[10] = 1'b1; end
              3'b110: begin cmd_d = C_ACT; ba_d = cmd_bank; addr_d = cmd_addr; end
              3'b111: begin
                cmd_d      = cmd_write ? C_WR : C_RD;
                ba_d       = cmd_bank;
                addr_d     = cmd_addr;
                addr_d[10] = 1'b0;
              end
              default: cmd_d = C_NOP;
            endcase
          end
        end
      default: cmd_d = C_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= C_NOP;
      sd_cke  <= 1'b1;
      sd_ba   <= '0;
      sd_addr <= '0;
    end else begin
      cmd_q   <= cmd_d;
      sd_cke  <= cke_d;
      sd_ba   <= ba_d;
      sd_addr <= addr_d;
    end
  end

  assign tick   = (pre_cnt == rfsh_scale - 8'd1);
  assign expire = init_done && tick && (per_cnt == rfsh_period - 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      per_cnt  <= '0;
      rfsh_req <= 1'b0;
    end else begin
      if (!init_done) begin
        pre_cnt <= '0;
        per_cnt <= '0;
      end else begin
        pre_cnt <= tick ? 8'd0 : pre_cnt + 8'd1;
        if (tick) per_cnt <= expire ? 8'd0 : per_cnt + 8'd1;
      end
      if (expire) rfsh_req <= 1'b1;
      else if (rfsh_ack) rfsh_req <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_trig,
  input logic              rfsh_ack,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              rfsh_req
);
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  assert_no_early_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (cmd != 4'b0011) && (cmd != 4'b0101) && (cmd != 4'b0100));

  assert_cke_high_in_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> cke);

  assert_mode_word_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (addr[8:7] == 2'b00) && (addr[ADDR_W-1:10] == '0) && (ba == '0));

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !rfsh_ack) |=> rfsh_req);

  assert_sr_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == 4'b0001));

  assert_idle_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !cmd_trig) |=> (cmd == 4'b0111));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_trig(cmd_trig), .rfsh_ack(rfsh_ack),
  .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
  .ba(sd_ba), .addr(sd_addr), .init_done(init_done), .rfsh_req(rfsh_req)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
  localparam int AW = 13;
  localparam int BW = 2;
  localparam int W  = 10;
  localparam int G  = 2;
  localparam int NR = 4;
  localparam int P_PALL = W + 1;
  localparam int P_MRS  = P_PALL + (G + 1) * (NR + 1);
  localparam int P_DONE = P_MRS + G;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_code = '0;
  logic cmd_trig = 1'b0, cmd_write = 1'b0;
  logic [BW-1:0] cmd_bank = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [1:0] cfg_bl = 2'b10, cfg_cl = 2'b11;
  logic cfg_bt = 1'b0, cfg_wb_single = 1'b0;
  logic [7:0] rfsh_period = 8'd3, rfsh_scale = 8'd4;
  logic rfsh_ack = 1'b0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done, rfsh_req;
  logic [BW-1:0] sd_ba;
  logic [AW-1:0] sd_addr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0, sr = 0;

  sdram_init_seq #(.ADDR_W(AW), .BA_W(BW), .WAIT_CYCLES(W), .NUM_REFRESH(NR), .CMD_GAP(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .cmd_trig(cmd_trig), .cmd_write(cmd_write),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cfg_bl(cfg_bl), .cfg_bt(cfg_bt), .cfg_cl(cfg_cl),
    .cfg_wb_single(cfg_wb_single), .rfsh_period(rfsh_period), .rfsh_scale(rfsh_scale),
    .rfsh_ack(rfsh_ack), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .init_done(init_done), .rfsh_req(rfsh_req));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  function automatic logic [19:0] pk(logic cke, logic [3:0] c, logic [BW-1:0] b, logic [AW-1:0] a);
    return {cke, c, b, a};
  endfunction

  function automatic logic [AW-1:0] mword(logic [1:0] bl, logic bt, logic [1:0] cl, logic wb);
    logic [AW-1:0] w = '0;
    w[1:0] = bl; w[3] = bt; w[5:4] = cl; w[9] = wb;
    return w;
  endfunction

  function automatic logic [19:0] init_exp(int c);
    logic [AW-1:0] a10 = '0;
    a10[10] = 1'b1;
    if (c == P_PALL) return pk(1, 4'b0010, '0, a10);
    for (int i = 1; i <= NR; i++)
      if (c == P_PALL + (G + 1) * i) return pk(1, 4'b0001, '0, '0);
    if (c == P_MRS) return pk(1, 4'b0000, '0, mword(cfg_bl, cfg_bt, cfg_cl, cfg_wb_single));
    return pk(1, 4'b0111, '0, '0);
  endfunction

  function automatic logic [19:0] pins();
    return {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cmd_step(logic trig, logic [2:0] op, logic [BW-1:0] b, logic [AW-1:0] a, logic wr);
    logic [19:0] e;
    logic [AW-1:0] x;
    string tag;
    cmd_trig = trig; op_code = op; cmd_bank = b; cmd_addr = a; cmd_write = wr;
    tag = "R6";
    if (!trig) e = pk(!sr, 4'b0111, '0, '0);
    else if (sr) begin e = pk(1, 4'b0111, '0, '0); sr = 0; tag = "R9"; end
    else begin
      x = '0;
      case (op)
        3'b000: begin e = pk(1, 4'b0111, '0, '0); tag = "R7"; end
        3'b001: e = pk(1, 4'b0001, '0, '0);
        3'b010: begin e = pk(0, 4'b0001, '0, '0); sr = 1; tag = "R9"; end
        3'b011: begin e = pk(1, 4'b0000, '0, mword(cfg_bl, cfg_bt, cfg_cl, cfg_wb_single)); tag = "R3"; end
        3'b100: begin e = pk(1, 4'b0010, b, '0); tag = "R8"; end
        3'b101: begin x[10] = 1'b1; e = pk(1, 4'b0010, '0, x); end
        3'b110: begin e = pk(1, 4'b0011, b, a); tag = "R8"; end
        default: begin x = a; x[10] = 1'b0; e = pk(1, wr ? 4'b0100 : 4'b0101, b, x); tag = "R8"; end
      endcase
    end
    @(negedge clk);
    chk(pins() == e, tag, 32'(pins()), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int dummy, t_done, t_req;
    dummy = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    chk(pins() == pk(1, 4'b0111, '0, '0), "R1", 32'(pins()), 32'(pk(1, 4'b0111, '0, '0)));
    chk({init_done, rfsh_req} == 2'b00, "R1", {init_done, rfsh_req}, 0);
    rst_n = 1'b1;
    cmd_trig = 1'b1; op_code = 3'b110; cmd_addr = 13'h0ABC; cmd_bank = 2'd2;
    // R2/R4/R5: init order with a trigger held active throughout
    do begin
      @(negedge clk);
      chk(pins() == init_exp(cyc), (cyc == P_MRS) ? "R3" : "R2", 32'(pins()), 32'(init_exp(cyc)));
      chk(init_done == (cyc >= P_DONE), "R4", init_done, cyc >= P_DONE);
    end while (cyc < P_DONE);
    cmd_trig = 1'b0;
    t_done = cyc;
    // R10/R11: refresh timer 3 x 4 = 12
    while (!rfsh_req) @(negedge clk);
    chk(cyc - t_done == 12, "R10", cyc - t_done, 12);
    rfsh_ack = 1'b1; @(negedge clk); rfsh_ack = 1'b0;
    chk(rfsh_req == 1'b0, "R11", rfsh_req, 0);
    while (!rfsh_req) @(negedge clk);
    chk(cyc - t_done == 24, "R10", cyc - t_done, 24);
    chk(init_done == 1'b1, "R4", init_done, 1);
    rfsh_ack = 1'b1; @(negedge clk); rfsh_ack = 1'b0;
    while (cyc < t_done + 35) @(negedge clk);
    rfsh_ack = 1'b1; @(negedge clk);
    chk(rfsh_req == 1'b1, "R11", rfsh_req, 1);
    @(negedge clk); rfsh_ack = 1'b0;
    chk(rfsh_req == 1'b0, "R11", rfsh_req, 0);
    // directed command-mode corners
    cmd_step(1, 3'b000, 2'd1, 13'h1FFF, 0);
    cmd_step(1, 3'b001, 2'd0, 13'h0000, 0);
    cmd_step(1, 3'b101, 2'd3, 13'h1234, 0);
    cmd_step(1, 3'b100, 2'd3, 13'h1234, 0);
    cmd_step(1, 3'b110, 2'd2, 13'h1F0F, 0);
    cmd_step(1, 3'b111, 2'd1, 13'h07FF, 1);
    cmd_step(1, 3'b111, 2'd1, 13'h07FF, 0);
    cfg_bl = 2'b11; cfg_bt = 1; cfg_cl = 2'b01; cfg_wb_single = 1;
    cmd_step(1, 3'b011, 2'd3, 13'h1FFF, 0);
    cmd_step(1, 3'b010, 2'd0, 13'h0000, 0);
    cmd_step(0, 3'b001, 2'd0, 13'h0000, 0);
    cmd_step(1, 3'b110, 2'd1, 13'h0155, 0);
    cmd_step(0, 3'b110, 2'd1, 13'h0155, 0);
    // constrained random command mode
    for (int i = 0; i < 400; i++) begin
      cfg_bl = 2'($urandom); cfg_bt = 1'($urandom);
      cfg_cl = 2'($urandom_range(3, 1)); cfg_wb_single = 1'($urandom);
      cmd_step(($urandom % 4) != 0, 3'($urandom), 2'($urandom), 13'($urandom), 1'($urandom));
    end
    cmd_step(1, 3'b000, 2'd0, 13'h0, 0);
    // second reset with the 39 x 39 refresh example
    @(negedge clk);
    cmd_trig = 0; rst_n = 0; rfsh_period = 8'd39; rfsh_scale = 8'd39; sr = 0;
    repeat (2) @(negedge clk);
    chk({sd_cke, init_done, rfsh_req} == 3'b100, "R1", {sd_cke, init_done, rfsh_req}, 3'b100);
    rst_n = 1;
    while (!init_done) @(negedge clk);
    chk(cyc == P_DONE, "R4", cyc, P_DONE);
    t_done = cyc;
    while (!rfsh_req) @(negedge clk);
    t_req = cyc;
    chk(t_req - t_done == 1521, "R10", t_req - t_done, 1521);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule